// File: doc/BRIEF.md
# I2C SCL clock waveform generator

This block sets the timing of the SCL line for an I2C master, using the system clock as its time base. A configuration word sets a low-phase divider, a high-phase divider and a power-of-two exponent that both dividers share. Each half period of SCL lasts `divider × 2^exponent + OFFSET` system clocks. OFFSET is a fixed per-variant constant, either 3 or 4. The exponent is limited to MAX_EXP, which is 5 or 7 depending on the variant.

The transfer engine uses `tick_o`, a one-cycle pulse on the last cycle of every half period, to step its bit sequence. `scl_o` toggles on the cycle after each tick. When `en_i` is low the block stays idle: the counters are held at zero and SCL is released high. Configuration writes are stored at once, but the running half period keeps its old timing. The new values apply from the next phase boundary.

The reset configuration gives a 100 kHz bus from a 200 MHz system clock with OFFSET = 4 (exponent 2, both dividers 249). Rates up to 400 kHz are intended.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is asserted or `en_i` is low, `scl_o` is 1 and `tick_o` is 0.
- R2: The first phase after `en_i` rises is high. A high phase lasts `hi_div × 2^exp + OFFSET` system clocks. `hi_div` is `cfg_i[15:8]` and `exp` is `cfg_i[18:16]`.
- R3: A low phase lasts `lo_div × 2^exp + OFFSET` system clocks, where `lo_div` is `cfg_i[7:0]`.
- R4: An exponent field value greater than MAX_EXP gives the same timing as MAX_EXP.
- R5: `tick_o` is high for exactly one cycle, the last cycle of each phase, and `scl_o` changes level in the next cycle and at no other time while enabled.
- R6: A write (`cfg_we_i` high) never changes the length of the phase in progress. The written word sets the length of every later phase. This includes a write made in the tick cycle itself.
- R7: Dropping `en_i` in the middle of a phase forces `scl_o` high in the next cycle. The next enable starts a full-length high phase.
- R8: A divider of zero gives a phase of exactly OFFSET cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the generator idle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 19 | Configuration word: exponent [18:16], high divider [15:8], low divider [7:0] |
| tick_o | output | 1 | One-cycle pulse on the last cycle of each phase |
| scl_o | output | 1 | SCL level (1 = released) |

## Verification
Asymmetric dividers with a small exponent confirm that the high and low phases each use their own field. An exponent above the cap combined with small dividers shows whether the clamp is applied. Zero dividers isolate the constant offset. A write made in the middle of a phase, followed by a disable in the middle of a phase, shows whether the running half period is protected and whether an enable restarts from a clean high phase. A long run of random configurations, random write times and random enable drops is then compared on every cycle against a behavioural model. This covers writes that land exactly on a tick, which directed patterns rarely reach.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
  localparam int DIV_W = 8;
  localparam int EXP_W = 3;
  localparam int CFG_W = EXP_W + 2 * DIV_W;

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [DIV_W-1:0] hi_div;
    logic [DIV_W-1:0] lo_div;
  } scl_cfg_t;
endpackage

// File: rtl/scl_cfg_store.sv
module scl_cfg_store
  import scl_clkgen_pkg::*;
#(
  parameter scl_cfg_t RST_CFG = '0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  scl_cfg_t wdata_i,
  input  logic     load_i,
  output scl_cfg_t act_o
);
  scl_cfg_t cfg_q, act_q;
  scl_cfg_t cfg_fwd;

  // a write in the boundary cycle is forwarded into the next phase
  assign cfg_fwd = we_i ? wdata_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RST_CFG;
      act_q <= RST_CFG;
    end else begin
      if (we_i) cfg_q <= wdata_i;
      if (load_i) act_q <= cfg_fwd;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len
  import scl_clkgen_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5,
  parameter int CNT_W   = DIV_W + MAX_EXP + 1
) (
  input  scl_cfg_t         cfg_i,
  input  logic             level_i,
  output logic [CNT_W-1:0] len_o
);
  logic [EXP_W-1:0] exp_eff;
  logic [DIV_W-1:0] div;

  generate
    if (MAX_EXP >= (1 << EXP_W) - 1) begin : g_no_clamp
      assign exp_eff = cfg_i.exp;
    end else begin : g_clamp
      assign exp_eff = (cfg_i.exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : cfg_i.exp;
    end
  endgenerate

  assign div   = level_i ? cfg_i.hi_div : cfg_i.lo_div;
  assign len_o = (CNT_W'(div) << exp_eff) + CNT_W'(OFFSET);
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             tick_o,
  output logic             scl_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             scl_q;

  assign tick_o = en_i && (cnt_q == len_i - CNT_W'(1));
  assign scl_o  = scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      scl_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      scl_q <= 1'b1;
    end else if (tick_o) begin
      cnt_q <= '0;
      scl_q <= ~scl_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_clkgen_pkg::*;
#(
  parameter int          OFFSET  = 4,
  parameter int          MAX_EXP = 5,
  parameter logic [18:0] RST_CFG = 19'h2F9F9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        cfg_we_i,
  input  logic [18:0] cfg_i,
  output logic        tick_o,
  output logic        scl_o
);
  localparam int CNT_W = DIV_W + MAX_EXP + 1;

  scl_cfg_t         act_cfg;
  logic [CNT_W-1:0] phase_len;
  logic             tick;
  logic             scl;

  scl_cfg_store #(
    .RST_CFG(scl_cfg_t'(RST_CFG))
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(scl_cfg_t'(cfg_i)),
    .load_i (tick || !en_i),
    .act_o  (act_cfg)
  );

  scl_phase_len #(
    .OFFSET (OFFSET),
    .MAX_EXP(MAX_EXP),
    .CNT_W  (CNT_W)
  ) u_len (
    .cfg_i  (act_cfg),
    .level_i(scl),
    .len_o  (phase_len)
  );

  scl_phase_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .len_i (phase_len),
    .tick_o(tick),
    .scl_o (scl)
  );

  assign tick_o = tick;
  assign scl_o  = scl;
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_o,
  input logic scl_o
);
  // R1
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> scl_o);
  // R1
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
  // R5
  tick_toggles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> scl_o != $past(scl_o));
  // R5
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R5
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> $stable(scl_o));
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .tick_o(tick_o),
  .scl_o (scl_o)
);

// File: tb/scl_clkgen_test.sv
`timescale 1ns/1ps
module scl_clkgen_test;
  localparam int          OFFSET  = 4;
  localparam int          MAX_EXP = 5;
  localparam logic [18:0] RST_CFG = 19'h2F9F9;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [18:0] cfg_i = '0;
  logic        tick_o, scl_o;

  int checks = 0;
  int errors = 0;

  scl_clkgen #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP), .RST_CFG(RST_CFG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .cfg_we_i(cfg_we_i),
    .cfg_i(cfg_i), .tick_o(tick_o), .scl_o(scl_o));

  always #2.5 clk = ~clk;

  function automatic int plen(logic [18:0] c, bit lvl);
    int e = int'(c[18:16]);
    if (e > MAX_EXP) e = MAX_EXP;
    return (lvl ? int'(c[15:8]) : int'(c[7:0])) * (1 << e) + OFFSET;
  endfunction

  function automatic logic [18:0] mk(int e, int hi, int lo);
    return {3'(e), 8'(hi), 8'(lo)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int          m_cnt;
  bit          m_scl;
  logic [18:0] m_cfg, m_act;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_scl = 1; m_cfg = RST_CFG; m_act = RST_CFG;
    end else begin
      bit t;
      t = en_i && (m_cnt == plen(m_act, m_scl) - 1);
      if (!en_i || t) m_act = cfg_we_i ? cfg_i : m_cfg;
      if (!en_i) begin
        m_cnt = 0; m_scl = 1;
      end else if (t) begin
        m_cnt = 0; m_scl = !m_scl;
      end else m_cnt++;
      if (cfg_we_i) m_cfg = cfg_i;
    end
  end

  bit prev_tick, prev_scl, prev_en;
  always @(negedge clk) begin
    if (rst_ni) begin
      bit exp_tick;
      exp_tick = en_i && (m_cnt == plen(m_act, m_scl) - 1);
      check(tick_o == exp_tick, "R5 tick vs model", int'(tick_o), int'(exp_tick));
      check(scl_o == m_scl, "R3 scl vs model", int'(scl_o), int'(m_scl));
      if (prev_en && en_i)
        check((scl_o != prev_scl) == prev_tick, "R5 toggle after tick",
              int'(scl_o), int'(prev_scl ^ prev_tick));
    end
    prev_tick = tick_o; prev_scl = scl_o; prev_en = en_i;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [18:0] c);
    cfg_i = c; cfg_we_i = 1'b1;
    step(1);
    cfg_we_i = 1'b0;
  endtask

  // counts cycles at the current level, starting from a negedge
  task automatic measure(output int n);
    bit lvl = scl_o;
    n = 0;
    while (scl_o == lvl) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_pair(logic [18:0] c, string rh, string rl);
    int h, l;
    en_i = 1'b0; step(2);
    wr(c);
    en_i = 1'b1;
    @(negedge clk);
    measure(h);
    check(h == plen(c, 1), rh, h, plen(c, 1));
    measure(l);
    check(l == plen(c, 0), rl, l, plen(c, 0));
    step(1);
  endtask

  initial begin
    int h, l;
    step(2);
    @(negedge clk);
    check(scl_o == 1'b1, "R1 reset scl", int'(scl_o), 1);
    check(tick_o == 1'b0, "R1 reset tick", int'(tick_o), 0);
    rst_ni = 1'b1;
    step(3);
    @(negedge clk);
    check(scl_o == 1'b1 && tick_o == 1'b0, "R1 idle", int'(scl_o), 1);
    step(1);

    run_pair(mk(1, 3, 5), "R2 high phase", "R3 low phase");
    run_pair(mk(0, 9, 2), "R2 high phase exp0", "R3 low phase exp0");
    run_pair(mk(7, 2, 1), "R4 clamp high", "R4 clamp low");
    run_pair(mk(6, 1, 0), "R4 clamp exp6", "R8 zero low divider");
    run_pair(mk(3, 0, 0), "R8 zero high", "R8 zero low");

    // R6: write in the middle of the high phase
    en_i = 1'b0; step(2);
    wr(mk(0, 10, 10));
    en_i = 1'b1;
    step(1);
    wr(mk(0, 20, 20));
    @(negedge clk);
    measure(h);
    check(h + 2 == 14, "R6 running phase kept", h + 2, 14);
    measure(l);
    check(l == 24, "R6 next phase uses write", l, 24);

    // R7: drop enable in the middle of the high phase
    step(3);
    en_i = 1'b0;
    @(negedge clk);
    check(scl_o == 1'b1, "R7 released on disable", int'(scl_o), 1);
    check(tick_o == 1'b0, "R7 no tick on disable", int'(tick_o), 0);
    step(2);
    en_i = 1'b1;
    @(negedge clk);
    measure(h);
    check(h == 24, "R7 full phase after enable", h, 24);

    // R6: write landing on the tick cycle
    en_i = 1'b0; step(2);
    wr(mk(0, 2, 2));
    en_i = 1'b1;
    step(5);
    wr(mk(0, 7, 7));
    @(negedge clk);
    measure(l);
    check(l == 11, "R6 write on tick applies next", l, 11);
    step(1);

    // random traffic compared against the model every cycle
    for (int i = 0; i < 60; i++) begin
      step($urandom_range(1, 120));
      if ($urandom_range(0, 9) == 0) begin
        en_i = 1'b0; step($urandom_range(1, 4)); en_i = 1'b1;
      end
      wr(mk($urandom_range(0, 7), $urandom_range(0, 12), $urandom_range(0, 12)));
    end
    step(200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule